// File: doc/BRIEF.md
# Inter-Stage Register Readiness Tracker

Several execution stages sit in a ring. Each stage runs one window of instructions against its own private future copy of the register file. This block decides two things. First, whether a read of a given register in a given stage must stall. Second, which register values each stage must send on to its successor.

Before a window's instructions arrive, its stage is loaded with two bitmasks, with one bit per architectural register:
- an *import* mask lists the registers whose values the window expects from older windows;
- an *export* mask lists the registers whose final values the window produces for younger windows.

Traffic between stages is limited to registers named in these masks. Ordering within one stage needs no tracking, because a stage executes its instructions serially.

When a stage reports a final write-back of an exported register, the block queues that register for forwarding to the next stage. A stage that receives a register it does not export itself relays the value onward. A stage that does export it stops the chain, because it will later produce its own value. No stage forwards into the ring's head stage, which holds the oldest window.

Top module: `rmf_top`

## Requirements
- R1: After reset, no read stalls in any stage and no stage raises a forward request.
- R2: The cycle after a mask load of stage s, a read of register r (r not 0) in s stalls exactly when bit r of the import mask is 1. Any forwards still queued in s are discarded.
- R3: A read of register 0 never stalls, even when bit 0 of the import mask is set.
- R4: A write-back of register r in stage s, with bit r of s's export mask set, raises fwd_vld[s] with fwd_reg slice s equal to r in the following cycle.
- R5: A write-back of a register that is absent from the stage's export mask raises no forward request.
- R6: When stage s forwards register r, a read of r in stage s+1 (modulo the stage count) no longer stalls from the next cycle on.
- R7: A stage that receives register r and does not export it raises its own forward request for r one cycle after receiving it.
- R8: A stage that receives register r and does export it does not pass r onward.
- R9: A stage whose successor is the head stage (head_idx) raises no forward request. Its queued forwards are held until the head moves.
- R10: A stage with several queued registers forwards one per cycle, lowest register number first.
- R11: If a mask load of stage s coincides with a forward arriving into s, the load wins and the forwarded register keeps the state the import mask gives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_vld | input | 1 | Load masks into a stage |
| load_stage | input | SW | Stage receiving the masks |
| load_use | input | NUM_REGS | Import mask: registers supplied by older windows |
| load_create | input | NUM_REGS | Export mask: registers this window passes on |
| wb_vld | input | 1 | Final write-back event |
| wb_stage | input | SW | Stage of the write-back |
| wb_reg | input | RW | Register written back |
| head_idx | input | SW | Stage holding the oldest window |
| rd_stage | input | SW | Stage of the read query |
| rd_reg | input | RW | Register of the read query |
| rd_stall | output | 1 | Queried read must wait |
| fwd_vld | output | NUM_STAGES | Per-stage forward request toward the successor |
| fwd_reg | output | NUM_STAGES*RW | Per-stage forwarded register number, slice s for stage s |

## Verification
After every mask load, the stall output is swept over every stage and register. This separates import bits from the fixed readiness of register 0. A value is sent down a chain that mixes relaying and exporting stages, which tells pass-through apart from blocking and shows the one-cycle hop delay. Write-backs of unexported registers check that unexported registers are ignored. Three queued registers are held behind the head and then released, which checks the release order. A mask load is made in the same cycle as an arriving forward, which checks that the load takes precedence.

// File: rtl/rmf_pkg.sv
package rmf_pkg;
  localparam int unsigned MAX_REGS = 64;

  // one-hot decode of a register number
  function automatic logic [MAX_REGS-1:0] reg_bit(input int unsigned idx);
    return {{(MAX_REGS-1){1'b0}}, 1'b1} << idx;
  endfunction

  // index of the lowest set bit, 0 when none is set
  function automatic int unsigned lowest_set(input logic [MAX_REGS-1:0] v);
    int unsigned pick;
    pick = 0;
    for (int i = MAX_REGS - 1; i >= 0; i--) begin
      if (v[i]) pick = i;
    end
    return pick;
  endfunction

  // successor stage in the ring
  function automatic int unsigned ring_next(input int unsigned s, input int unsigned n);
    return (s + 1) % n;
  endfunction
endpackage

// File: rtl/rmf_pick.sv
module rmf_pick #(
  parameter int unsigned W  = 32,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  grant
);
  import rmf_pkg::*;

  logic [MAX_REGS-1:0] wide;

  always_comb begin
    wide  = '0;
    wide[W-1:0] = req;
    any   = |req;
    idx   = IW'(lowest_set(wide));
    grant = any ? W'(reg_bit(int'(idx))) : '0;
  end
endmodule

// File: rtl/rmf_slot.sv
module rmf_slot #(
  parameter int unsigned R  = 32,
  localparam int unsigned RW = $clog2(R)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [R-1:0]  use_in,
  input  logic [R-1:0]  create_in,
  input  logic          wb_hit,
  input  logic [RW-1:0] wb_reg,
  input  logic          in_vld,
  input  logic [RW-1:0] in_reg,
  input  logic          pass_ok,
  output logic          out_vld,
  output logic [RW-1:0] out_reg,
  output logic [R-1:0]  ready
);
  import rmf_pkg::*;

  logic [R-1:0] create_q;
  logic [R-1:0] pend_q;
  logic [R-1:0] wb_bit;
  logic [R-1:0] in_bit;
  logic [R-1:0] relay_bit;
  logic [R-1:0] grant;
  logic [R-1:0] grant_used;
  logic         pend_any;

  rmf_pick #(.W(R)) pick_i (
    .req   (pend_q),
    .any   (pend_any),
    .idx   (out_reg),
    .grant (grant)
  );

  always_comb begin
    wb_bit     = wb_hit ? (R'(reg_bit(int'(wb_reg))) & create_q) : '0;
    in_bit     = in_vld ? R'(reg_bit(int'(in_reg))) : '0;
    relay_bit  = in_bit & ~create_q;
    out_vld    = pend_any & pass_ok;
    grant_used = out_vld ? grant : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready    <= '1;
      create_q <= '0;
      pend_q   <= '0;
    end else if (load) begin
      ready    <= ~use_in | R'(1);
      create_q <= create_in;
      pend_q   <= '0;
    end else begin
      ready    <= ready | in_bit;
      pend_q   <= (pend_q & ~grant_used) | wb_bit | relay_bit;
    end
  end
endmodule

// File: rtl/rmf_top.sv
module rmf_top #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned NUM_REGS   = 32,
  localparam int unsigned SW = $clog2(NUM_STAGES),
  localparam int unsigned RW = $clog2(NUM_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_vld,
  input  logic [SW-1:0]            load_stage,
  input  logic [NUM_REGS-1:0]      load_use,
  input  logic [NUM_REGS-1:0]      load_create,
  input  logic                     wb_vld,
  input  logic [SW-1:0]            wb_stage,
  input  logic [RW-1:0]            wb_reg,
  input  logic [SW-1:0]            head_idx,
  input  logic [SW-1:0]            rd_stage,
  input  logic [RW-1:0]            rd_reg,
  output logic                     rd_stall,
  output logic [NUM_STAGES-1:0]    fwd_vld,
  output logic [NUM_STAGES*RW-1:0] fwd_reg
);
  import rmf_pkg::*;

  logic [NUM_STAGES*NUM_REGS-1:0] rdy_flat;
  logic [NUM_STAGES-1:0]          load_hit;
  logic [NUM_STAGES-1:0]          wb_hit;
  logic [NUM_STAGES-1:0]          pass_ok;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    localparam int unsigned PRV = (s + NUM_STAGES - 1) % NUM_STAGES;
    localparam int unsigned NXT = ring_next(s, NUM_STAGES);

    assign load_hit[s] = load_vld && (load_stage == SW'(s));
    assign wb_hit[s]   = wb_vld && (wb_stage == SW'(s));
    assign pass_ok[s]  = (head_idx != SW'(NXT));

    rmf_slot #(.R(NUM_REGS)) slot_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_hit[s]),
      .use_in    (load_use),
      .create_in (load_create),
      .wb_hit    (wb_hit[s]),
      .wb_reg    (wb_reg),
      .in_vld    (fwd_vld[PRV]),
      .in_reg    (fwd_reg[PRV*RW +: RW]),
      .pass_ok   (pass_ok[s]),
      .out_vld   (fwd_vld[s]),
      .out_reg   (fwd_reg[s*RW +: RW]),
      .ready     (rdy_flat[s*NUM_REGS +: NUM_REGS])
    );
  end

  always_comb begin
    rd_stall = (rd_reg != '0) && !rdy_flat[int'(rd_stage)*NUM_REGS + int'(rd_reg)];
  end
endmodule

// File: rtl/rmf_chk.sv
module rmf_chk #(
  parameter int unsigned N  = 4,
  parameter int unsigned R  = 32,
  localparam int unsigned SW = $clog2(N),
  localparam int unsigned RW = $clog2(R)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            load_vld,
  input logic [SW-1:0]   load_stage,
  input logic [SW-1:0]   head_idx,
  input logic [RW-1:0]   rd_reg,
  input logic            rd_stall,
  input logic [N-1:0]    fwd_vld,
  input logic [N*RW-1:0] fwd_reg,
  input logic [N*R-1:0]  rdy_flat
);
  // R3
  r0_never_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_reg == '0) |-> !rd_stall);

  for (genvar s = 0; s < N; s++) begin : g_chk
    localparam int unsigned NXT = (s + 1) % N;
    logic [RW-1:0] fr;
    assign fr = fwd_reg[s*RW +: RW];

    // R2
    load_clears_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_vld && load_stage == SW'(s)) |=> !fwd_vld[s]);

    // R6
    forward_marks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_vld[s] && !(load_vld && load_stage == SW'(NXT)))
        |=> rdy_flat[NXT*R + int'($past(fr))]);

    // R9
    no_forward_into_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_vld[s] |-> (head_idx != SW'(NXT)));

    // R6
    ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_vld && load_stage == SW'(s))
        |=> ((rdy_flat[s*R +: R] & $past(rdy_flat[s*R +: R])) == $past(rdy_flat[s*R +: R])));
  end
endmodule

bind rmf_top rmf_chk #(.N(NUM_STAGES), .R(NUM_REGS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_vld   (load_vld),
  .load_stage (load_stage),
  .head_idx   (head_idx),
  .rd_reg     (rd_reg),
  .rd_stall   (rd_stall),
  .fwd_vld    (fwd_vld),
  .fwd_reg    (fwd_reg),
  .rdy_flat   (rdy_flat)
);

// File: tb/rmf_top_tb_top.sv
module rmf_top_tb_top;
  localparam int N = 4;
  localparam int R = 8;
  localparam int SW = 2;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_vld = 1'b0;
  logic [SW-1:0] load_stage = '0;
  logic [R-1:0]  load_use = '0;
  logic [R-1:0]  load_create = '0;
  logic          wb_vld = 1'b0;
  logic [SW-1:0] wb_stage = '0;
  logic [RW-1:0] wb_reg = '0;
  logic [SW-1:0] head_idx = '0;
  logic [SW-1:0] rd_stage = '0;
  logic [RW-1:0] rd_reg = '0;
  logic          rd_stall;
  logic [N-1:0]  fwd_vld;
  logic [N*RW-1:0] fwd_reg;

  int n_chk = 0;
  int n_bad = 0;
  logic [R-1:0] use_m [N];

  always #5 clk = ~clk;

  rmf_top #(.NUM_STAGES(N), .NUM_REGS(R)) dut_i (.*);

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int fr(input int s);
    return int'(fwd_reg[s*RW +: RW]);
  endfunction

  task automatic stall_is(input int s, input int r, input bit exp, input string tag);
    rd_stage = SW'(s);
    rd_reg   = RW'(r);
    #1;
    chk(rd_stall == exp, tag, int'(rd_stall), int'(exp));
  endtask

  task automatic load(input int s, input logic [R-1:0] u, input logic [R-1:0] c);
    load_vld = 1'b1; load_stage = SW'(s); load_use = u; load_create = c;
    use_m[s] = u;
    step();
    load_vld = 1'b0;
  endtask

  task automatic wb(input int s, input int r);
    wb_vld = 1'b1; wb_stage = SW'(s); wb_reg = RW'(r);
    step();
    wb_vld = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1: reset state
    for (int s = 0; s < N; s++)
      for (int r = 0; r < R; r++) stall_is(s, r, 1'b0, "R1 reset stall");
    chk(fwd_vld == '0, "R1 reset fwd", int'(fwd_vld), 0);

    // R2/R3: mask loads, full sweep
    load(0, 8'h01, 8'h10);
    load(1, 8'h11, 8'h00);
    load(2, 8'h10, 8'h10);
    load(3, 8'h90, 8'h00);
    for (int s = 0; s < N; s++)
      for (int r = 0; r < R; r++)
        stall_is(s, r, (r != 0) && use_m[s][r], r == 0 ? "R3 reg0 ready" : "R2 import stall");

    // R4: export write-back raises forward
    wb(0, 4);
    chk(fwd_vld == 4'b0001, "R4 fwd_vld", int'(fwd_vld), 1);
    chk(fr(0) == 4, "R4 fwd_reg", fr(0), 4);
    stall_is(1, 4, 1'b1, "R6 not yet ready");
    step();
    stall_is(1, 4, 1'b0, "R6 ready after hop");
    chk(fwd_vld == 4'b0010, "R7 relay vld", int'(fwd_vld), 2);
    chk(fr(1) == 4, "R7 relay reg", fr(1), 4);
    step();
    stall_is(2, 4, 1'b0, "R6 stage2 ready");
    chk(fwd_vld == 4'b0000, "R8 blocked", int'(fwd_vld), 0);
    stall_is(3, 4, 1'b1, "R8 stage3 waits");
    wb(2, 4);
    chk(fwd_vld == 4'b0100, "R4 stage2 fwd", int'(fwd_vld), 4);
    step();
    stall_is(3, 4, 1'b0, "R6 stage3 ready");
    chk(fwd_vld == 4'b0000, "R9 no fwd into head", int'(fwd_vld), 0);
    stall_is(3, 7, 1'b1, "R2 other import waits");

    // R5: unexported write-backs ignored
    wb(1, 6);
    chk(fwd_vld == 4'b0000, "R5 unexported s1", int'(fwd_vld), 0);
    wb(0, 3);
    chk(fwd_vld == 4'b0000, "R5 unexported s0", int'(fwd_vld), 0);

    // R9/R10: queue behind head, release in order
    load(3, 8'h00, 8'h00);
    head_idx = 2'd1;
    load(0, 8'h00, 8'h2C);
    wb(0, 5);
    chk(fwd_vld[0] == 1'b0, "R9 held 5", int'(fwd_vld[0]), 0);
    wb(0, 3);
    chk(fwd_vld[0] == 1'b0, "R9 held 3", int'(fwd_vld[0]), 0);
    wb(0, 2);
    chk(fwd_vld[0] == 1'b0, "R9 held 2", int'(fwd_vld[0]), 0);
    head_idx = 2'd2;
    load_vld = 1'b1; load_stage = 2'd1; load_use = 8'h2C; load_create = 8'h00;
    #1;
    chk(fwd_vld[0] && fr(0) == 2, "R10 first reg2", fr(0), 2);
    step();
    load_vld = 1'b0;
    stall_is(1, 2, 1'b1, "R11 load wins");
    stall_is(1, 3, 1'b1, "R10 reg3 pending");
    chk(fwd_vld[0] && fr(0) == 3, "R10 second reg3", fr(0), 3);
    step();
    stall_is(1, 3, 1'b0, "R6 reg3 arrived");
    chk(fwd_vld[0] && fr(0) == 5, "R10 third reg5", fr(0), 5);
    chk(fwd_vld[1] == 1'b0, "R9 s1 held", int'(fwd_vld[1]), 0);
    step();
    stall_is(1, 5, 1'b0, "R6 reg5 arrived");
    chk(fwd_vld[0] == 1'b0, "R10 queue empty", int'(fwd_vld[0]), 0);

    // R2: reload discards held forwards
    load(1, 8'h00, 8'h00);
    head_idx = 2'd0;
    #1;
    chk(fwd_vld == 4'b0000, "R2 queue discarded", int'(fwd_vld), 0);
    step();
    chk(fwd_vld == 4'b0000, "R2 still quiet", int'(fwd_vld), 0);

    finish_run();
  end
endmodule